// File: doc/BRIEF.md
# Serial Converter Word Capture and Latch

This block is the digital front end of a 14-bit voltage-output converter. A host writes a code over a three-wire serial link (active-low select, serial clock, data). The bits are shifted, most significant first, into a capture register. A transfer then copies the captured word into the converter latch. The latch value is presented as a binary code and as a thermometer vector for the upper segment switches.

The serial pins are sampled by the block's own clock. They are assumed to be already synchronous to that clock and slower than half its rate. Edges on them are found by comparing each pin with its value one cycle earlier. A mode input picks the transfer event. In select mode the word is transferred when select returns high. In strobe mode the word is transferred when a separate active-low load strobe falls while select is high. The capture register has no reset, so a short frame keeps part of the previous contents and a long frame keeps only the most recent bits.

Top module: `dacif_front`

## Requirements
- R1: While `cs_n_i` is low, each rising edge of `sclk_i` shifts `din_i` into bit 0 of the capture register and moves every other bit up one place, so a 14-bit frame sent most significant bit first arrives in its original order.
- R2: Rising edges of `sclk_i` while `cs_n_i` is high change neither the capture register nor the latch.
- R3: With `mode_i` = 0, a low-to-high change of `cs_n_i` copies the capture register into `code_o`. `updated_o` is high for exactly the one cycle after that transfer and low at all other times.
- R4: If more than 14 bits arrive in one frame, the latched word is the last 14 bits received.
- R5: If k < 14 bits arrive in one frame, the latched word is the previous capture contents shifted up by k places, with the k new bits in bits k-1..0.
- R6: Reset clears `code_o` and `seg_o` to zero and holds `updated_o` low. The capture register is not reset.
- R7: With `mode_i` = 1, a rise of `cs_n_i` while `ld_n_i` is high does not transfer. A fall of `ld_n_i` while `cs_n_i` is high transfers the capture register.
- R8: With `mode_i` = 1, a fall of `ld_n_i` while `cs_n_i` is low has no effect on the latch.
- R9: With `mode_i` = 1 and `ld_n_i` held low, a rise of `cs_n_i` transfers the capture register.
- R10: `seg_o[k]` is 1 exactly when `code_o[13:10]` exceeds k, for k = 0..14. Bits 9..0 of `code_o` are the binary ladder controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| mode_i | input | 1 | 0: transfer on select rise; 1: transfer on load strobe |
| cs_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial bit clock |
| din_i | input | 1 | Serial data |
| ld_n_i | input | 1 | Active-low load strobe |
| code_o | output | 14 | Latched converter code |
| seg_o | output | 15 | Thermometer controls for the upper segments |
| updated_o | output | 1 | One-cycle pulse after each transfer |

## Verification
The design compares each pin with its value one cycle earlier. A pin change driven between two clock edges is therefore acted on at the next rising edge. At that edge a serial bit enters the capture register and a transfer loads the latch and sets `updated_o`. `seg_o` follows the latch with no extra register. The bench changes inputs on falling edges and checks `code_o`, `seg_o` and `updated_o` on the next falling edge, which is the half cycle after the transfer edge. It checks the pulse again one cycle later to confirm that it has ended. The contents of the capture register cannot be seen directly. The bench exposes them by following a frame of ignored clocks with a frame that has no bits, so that the transfer shows the register unchanged.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int unsigned CODE_W = 14;
  localparam int unsigned SEG_BITS = 4;
  localparam int unsigned SEG_N = (1 << SEG_BITS) - 1;
  localparam int unsigned LADDER_W = CODE_W - SEG_BITS;

  typedef enum logic {
    XFER_ON_SELECT = 1'b0,
    XFER_ON_STROBE = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/dacif_edge.sv
module dacif_edge #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb prev_d = sig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
    assign fall_o[i] = ~sig_i[i] & prev_q[i];
  end
endmodule

// File: rtl/dacif_shift.sv
module dacif_shift #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_rise_i,
  input  logic         cs_n_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         shift_en;

  always_comb begin
    shift_en = sclk_rise_i & ~cs_n_i;
    word_d   = {word_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (shift_en) word_q <= word_d;
  end

  assign word_o = word_q;

  assert_new_bit_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise_i && !cs_n_i) |=> (word_q[0] == $past(bit_i)));
  assert_bits_move_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise_i && !cs_n_i) |=> (word_q[W-1:1] == $past(word_q[W-2:0])));
  assert_idle_clock_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise_i && cs_n_i) |=> $stable(word_q));
endmodule

// File: rtl/dacif_latch.sv
module dacif_latch
  import dacif_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xfer_mode_e   mode_i,
  input  logic         cs_rise_i,
  input  logic         ld_fall_i,
  input  logic         cs_n_i,
  input  logic         ld_n_i,
  input  logic [W-1:0] shift_i,
  output logic [W-1:0] code_o,
  output logic         upd_o
);
  logic [W-1:0] code_q, code_d;
  logic         upd_q, upd_d;
  logic         xfer;

  always_comb begin
    unique case (mode_i)
      XFER_ON_SELECT: xfer = cs_rise_i;
      XFER_ON_STROBE: xfer = (ld_fall_i & cs_n_i) | (cs_rise_i & ~ld_n_i);
      default:        xfer = 1'b0;
    endcase
    code_d = xfer ? shift_i : code_q;
    upd_d  = xfer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= upd_d;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;

  assert_xfer_copies_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (code_q == $past(shift_i)));
  assert_hold_without_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_d |=> $stable(code_q));
  assert_strobe_needs_select_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == XFER_ON_STROBE && !cs_n_i) |=> !upd_q);
  assert_select_mode_ignores_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == XFER_ON_SELECT && !cs_rise_i) |=> !upd_q);
endmodule

// File: rtl/dacif_seg.sv
module dacif_seg
  import dacif_pkg::*;
(
  input  logic                rst_n,
  input  logic [SEG_BITS-1:0] msb_i,
  output logic [SEG_N-1:0]    seg_o
);
  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign seg_o[k] = (msb_i > SEG_BITS'(k));
  end

  always_comb begin
    if (rst_n) begin
      assert_seg_count_R10: assert ($countones(seg_o) == int'(msb_i));
      assert_seg_shape_R10: assert (((seg_o + SEG_N'(1)) & seg_o) == '0);
    end
  end
endmodule

// File: rtl/dacif_front.sv
module dacif_front
  import dacif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              ld_n_i,
  output logic [CODE_W-1:0] code_o,
  output logic [SEG_N-1:0]  seg_o,
  output logic              updated_o
);
  logic [2:0]        pin_rise, pin_fall;
  logic [CODE_W-1:0] shift_word;
  xfer_mode_e        mode;

  assign mode = xfer_mode_e'(mode_i);

  // bit 2: load strobe, bit 1: select, bit 0: serial clock
  dacif_edge #(.N(3), .RST_VAL(3'b010)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({ld_n_i, cs_n_i, sclk_i}),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  dacif_shift #(.W(CODE_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_rise_i (pin_rise[0]),
    .cs_n_i      (cs_n_i),
    .bit_i       (din_i),
    .word_o      (shift_word)
  );

  dacif_latch #(.W(CODE_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .cs_rise_i (pin_rise[1]),
    .ld_fall_i (pin_fall[2]),
    .cs_n_i    (cs_n_i),
    .ld_n_i    (ld_n_i),
    .shift_i   (shift_word),
    .code_o    (code_o),
    .upd_o     (updated_o)
  );

  dacif_seg u_seg (
    .rst_n (rst_n),
    .msb_i (code_o[CODE_W-1 -: SEG_BITS]),
    .seg_o (seg_o)
  );

  assert_reset_clears_R6: assert property (@(posedge clk)
    !rst_n |=> (code_o == '0 && !updated_o));
endmodule

// File: tb/dacif_front_tb.sv
module dacif_front_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode, cs_n, sclk, din, ld_n;
  logic [13:0] code;
  logic [14:0] seg;
  logic        upd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [13:0] sh;
  logic [13:0] exp_code;

  always #2.5 clk = ~clk;

  dacif_front u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cs_n_i(cs_n), .sclk_i(sclk),
    .din_i(din), .ld_n_i(ld_n), .code_o(code), .seg_o(seg), .updated_o(upd)
  );

  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{14'h3FFF, 14'h2000, 14'h0001, 14'h1555,
                                       14'h2AAA, 14'h0400, 14'h03FF, 14'h3C00};

  function automatic logic [14:0] thermo(input logic [13:0] c);
    logic [14:0] t;
    for (int k = 0; k < 15; k++) t[k] = (int'(c[13:10]) > k);
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); din = b; sclk = 1'b1;
    if (!cs_n) sh = {sh[12:0], b};
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic open_frame;
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  // raises select; returns on the falling edge after the transfer edge
  task automatic close_frame;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_loaded(input string req);
    check(req, 32'(upd), 32'd1);
    check(req, 32'(code), 32'(exp_code));
    check({req, "_seg"}, 32'(seg), 32'(thermo(exp_code)));
    @(negedge clk);
    check({req, "_pulse_end"}, 32'(upd), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; ld_n = 1'b1;
    sh = '0;
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6_code", 32'(code), 32'd0);
    check("R6_seg", 32'(seg), 32'd0);
    check("R6_upd", 32'(upd), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R3, R10: table of full frames in select mode
    for (int v = 0; v < NV; v++) begin
      open_frame();
      send_bits({2'b00, VEC[v]}, 14);
      exp_code = VEC[v];
      check("R1_shadow", 32'(sh), 32'(VEC[v]));
      close_frame();
      check_loaded("R1_R3_R10");
    end

    // R2: clocks with select high are ignored
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    check("R2_latch_hold", 32'(code), 32'(exp_code));
    check("R2_no_pulse", 32'(upd), 32'd0);
    open_frame();
    exp_code = sh;
    close_frame();
    check_loaded("R2_shift_hold");

    // R4: overrun keeps the last 14 bits
    open_frame();
    send_bits(16'hF00D, 16);
    exp_code = 14'h300D;
    close_frame();
    check_loaded("R4");

    // R5: underrun keeps earlier bits shifted up
    open_frame(); send_bits(16'h1234, 14); close_frame(); @(negedge clk);
    open_frame(); send_bits(16'h02AA, 10);
    exp_code = 14'h12AA;
    close_frame();
    check_loaded("R5");

    // R7: strobe mode
    mode = 1'b1;
    open_frame(); send_bits(16'h0777, 14);
    close_frame();
    check("R7_no_select_xfer", 32'(upd), 32'd0);
    check("R7_code_hold", 32'(code), 32'h12AA);
    @(negedge clk); ld_n = 1'b0;
    exp_code = 14'h0777;
    @(negedge clk);
    check_loaded("R7");
    ld_n = 1'b1;
    @(negedge clk);

    // R8: strobe while select low is ignored
    open_frame(); send_bits(16'h0055, 7);
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk);
    check("R8_no_pulse", 32'(upd), 32'd0);
    check("R8_code_hold", 32'(code), 32'h0777);
    ld_n = 1'b1;
    send_bits(16'h0055, 7);
    close_frame();
    check("R8_after_frame", 32'(upd), 32'd0);
    @(negedge clk); ld_n = 1'b0;
    exp_code = {7'h55, 7'h55};
    @(negedge clk);
    check_loaded("R8_R7_load");
    ld_n = 1'b1;
    @(negedge clk);

    // R9: strobe held low, select rise transfers
    ld_n = 1'b0;
    repeat (3) @(negedge clk);
    open_frame(); send_bits(16'h2468, 14);
    exp_code = 14'h2468;
    close_frame();
    check_loaded("R9");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule